// File: doc/BRIEF.md
# Two-Operand ALU with Status Flags

This block is the execute stage of a small processor datapath for operations that take two operands. It takes a source and a destination value and an operation code. It returns the result at byte, word or 20-bit address width. Every operation combines the two operands in one combinational pass. Alongside the result it produces a write-back strobe, which tells the register file or memory stage whether the destination should be overwritten.

Four status flags are held in a register: overflow (V), negative (N), zero (Z) and carry (C). The register loads on a clock edge only when the update enable is high and the selected operation is one that affects flags. Each operation follows its own flag rule:
- Arithmetic operations, compare and the decimal add derive all four flags from the result.
- The logic tests tie C to the inverse of Z.
- Move, bit clear and bit set leave the flags alone.

The incoming carry is an input, so the caller supplies the carry used by the carry-chained operations.

Top module: `dual_op_alu`

## Requirements
- R1: Operation codes are 0 move (src), 1 add, 2 add with carry, 3 subtract, 4 subtract with carry, 5 compare, 6 decimal add, 7 bit test (src AND dst), 8 bit clear (NOT src AND dst), 9 bit set (src OR dst), 10 exclusive OR, 11 AND. The result of 0, 8, 9, 10 and 11 is that combination of the operands.
- R2: Add is dst+src, add with carry is dst+src+cin, subtract is dst+NOT src+1, subtract with carry is dst+NOT src+cin. C is the carry out of the selected width's top bit, and V is two's-complement overflow at that width.
- R3: Compare produces dst+NOT src+1 and updates all four flags as subtract does, with write-back low.
- R4: Decimal add treats both operands as packed BCD with 2, 4 or 5 digits (byte, word, address) and adds cin. Each digit whose sum exceeds 9 is corrected by +6. C is the carry out of the top digit and V is cleared.
- R5: Width select 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 20 bits. Result bits above the width read 0. N is result bit 7, 15 or 19, and Z is set when the result at that width is zero.
- R6: Move, bit clear and bit set never change any flag.
- R7: Bit test and AND clear V and set C to NOT Z. Bit test has write-back low, and AND has write-back high.
- R8: Exclusive OR sets V when both operands are negative at the selected width, and sets C to NOT Z.
- R9: Flags change only on a rising clock edge where the update enable is high and the operation affects flags. Otherwise they hold.
- R10: An active-low asynchronous reset clears all four flags.
- R11: Codes 12 to 15 produce result 0, write-back low and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| wsel_i | input | 2 | Width select |
| src_i | input | 20 | Source operand |
| dst_i | input | 20 | Destination operand |
| cin_i | input | 1 | Incoming carry |
| flag_en_i | input | 1 | Flag update enable |
| res_o | output | 20 | Result, zero above the selected width |
| wb_o | output | 1 | Write-back enable |
| v_o | output | 1 | Overflow flag |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |

## Verification
The hardest case to reach is a decimal carry that ripples through every digit at the widest width, where a digit sum of exactly 9 plus the incoming carry must propagate. The stimulus pairs all-nines operands with small addends and a set carry-in, and checks them at each width.

A second hard case is a flag that must stay unchanged while the result changes. The bench gets there in two ways:
- It runs an operation that would set every flag while the update enable is low.
- It follows operations that set flags with moves and bit-set operations, which leave the flags alone.

// File: rtl/alu2_pkg.sv
package alu2_pkg;
  localparam int unsigned AW  = 20;
  localparam int unsigned WW  = 16;
  localparam int unsigned BW  = 8;
  localparam int unsigned NW  = 4;
  localparam int unsigned NDIG = AW / NW;

  typedef logic [4:0] bitidx_t;

  typedef enum logic [3:0] {
    OP_MOV = 4'd0, OP_ADD = 4'd1, OP_ADDC = 4'd2, OP_SUB = 4'd3,
    OP_SUBC = 4'd4, OP_CMP = 4'd5, OP_DADD = 4'd6, OP_BIT = 4'd7,
    OP_BIC = 4'd8, OP_BIS = 4'd9, OP_XOR = 4'd10, OP_AND = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

  typedef struct packed {
    logic [AW-1:0] r;
    logic          c;
    logic          v;
  } sum_t;

  function automatic logic [AW-1:0] wmask(input logic [1:0] w);
    case (w)
      2'd0:    return {{(AW-BW){1'b0}}, {BW{1'b1}}};
      2'd1:    return {{(AW-WW){1'b0}}, {WW{1'b1}}};
      default: return {AW{1'b1}};
    endcase
  endfunction

  function automatic bitidx_t wmsb(input logic [1:0] w);
    case (w)
      2'd0:    return bitidx_t'(BW - 1);
      2'd1:    return bitidx_t'(WW - 1);
      default: return bitidx_t'(AW - 1);
    endcase
  endfunction

  function automatic sum_t bin_add(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                   input logic ci, input logic [1:0] w);
    logic [AW-1:0] m;
    logic [AW:0]   s;
    bitidx_t       t;
    sum_t          o;
    m   = wmask(w);
    t   = wmsb(w);
    s   = {1'b0, a & m} + {1'b0, b & m} + {{AW{1'b0}}, ci};
    o.r = s[AW-1:0] & m;
    o.c = s[t + 5'd1];
    o.v = (a[t] == b[t]) && (o.r[t] != a[t]);
    return o;
  endfunction

  function automatic sum_t bcd_add(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                   input logic ci, input logic [1:0] w);
    logic        c;
    logic [NW:0] t;
    int unsigned nd;
    sum_t        o;
    nd  = (w == 2'd0) ? BW / NW : (w == 2'd1) ? WW / NW : NDIG;
    c   = ci;
    o.r = '0;
    for (int unsigned k = 0; k < NDIG; k++) begin
      if (k < nd) begin
        t = {1'b0, a[k*NW +: NW]} + {1'b0, b[k*NW +: NW]} + {{NW{1'b0}}, c};
        if (t > (NW+1)'(9)) begin
          t = t + (NW+1)'(6);
          c = 1'b1;
        end else begin
          c = 1'b0;
        end
        o.r[k*NW +: NW] = t[NW-1:0];
      end
    end
    o.c = c;
    o.v = 1'b0;
    return o;
  endfunction
endpackage

// File: rtl/alu2_addsub.sv
module alu2_addsub
  import alu2_pkg::*;
(
  input  logic [3:0]    op_i,
  input  logic [1:0]    wsel_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic          cin_i,
  output sum_t          sum_o
);
  logic          invert;
  logic          carry_in;
  logic [AW-1:0] b_opnd;

  always_comb begin
    invert   = (op_i == OP_SUB) || (op_i == OP_SUBC) || (op_i == OP_CMP);
    carry_in = ((op_i == OP_ADDC) || (op_i == OP_SUBC)) ? cin_i :
               ((op_i == OP_SUB) || (op_i == OP_CMP));
    b_opnd   = invert ? ~src_i : src_i;
  end

  assign sum_o = bin_add(dst_i, b_opnd, carry_in, wsel_i);
endmodule

// File: rtl/alu2_bcd.sv
module alu2_bcd
  import alu2_pkg::*;
(
  input  logic [1:0]    wsel_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic          cin_i,
  output sum_t          sum_o
);
  assign sum_o = bcd_add(src_i, dst_i, cin_i, wsel_i);
endmodule

// File: rtl/alu2_flagreg.sv
module alu2_flagreg
  import alu2_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_i,
  input  flags_t nxt_i,
  output flags_t q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= nxt_i;
  end
endmodule

// File: rtl/dual_op_alu.sv
module dual_op_alu
  import alu2_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op_i,
  input  logic [1:0]    wsel_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic          cin_i,
  input  logic          flag_en_i,
  output logic [AW-1:0] res_o,
  output logic          wb_o,
  output logic          v_o,
  output logic          n_o,
  output logic          z_o,
  output logic          c_o
);
  sum_t          as_sum;
  sum_t          bcd_sum;
  logic [AW-1:0] mask;
  bitidx_t       msb;
  logic [AW-1:0] s_m;
  logic [AW-1:0] d_m;
  logic [AW-1:0] res;
  logic          flag_touch;
  logic          res_zero;
  logic          v_nxt;
  logic          c_nxt;
  flags_t        flags_nxt;
  flags_t        flags_q;

  alu2_addsub u_addsub (
    .op_i(op_i), .wsel_i(wsel_i), .src_i(src_i), .dst_i(dst_i),
    .cin_i(cin_i), .sum_o(as_sum)
  );

  alu2_bcd u_bcd (
    .wsel_i(wsel_i), .src_i(src_i), .dst_i(dst_i),
    .cin_i(cin_i), .sum_o(bcd_sum)
  );

  assign mask     = wmask(wsel_i);
  assign msb      = wmsb(wsel_i);
  assign s_m      = src_i & mask;
  assign d_m      = dst_i & mask;
  assign res_zero = (res == '0);

  always_comb begin
    res        = '0;
    wb_o       = 1'b0;
    flag_touch = 1'b0;
    v_nxt      = 1'b0;
    c_nxt      = 1'b0;
    case (op_i)
      OP_MOV: begin res = s_m; wb_o = 1'b1; end
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        res        = as_sum.r;
        wb_o       = (op_i != OP_CMP);
        flag_touch = 1'b1;
        v_nxt      = as_sum.v;
        c_nxt      = as_sum.c;
      end
      OP_DADD: begin
        res        = bcd_sum.r;
        wb_o       = 1'b1;
        flag_touch = 1'b1;
        v_nxt      = bcd_sum.v;
        c_nxt      = bcd_sum.c;
      end
      OP_BIT, OP_AND: begin
        res        = s_m & d_m;
        wb_o       = (op_i == OP_AND);
        flag_touch = 1'b1;
        c_nxt      = ~res_zero;
      end
      OP_BIC: begin res = ~s_m & d_m; wb_o = 1'b1; end
      OP_BIS: begin res = s_m | d_m;  wb_o = 1'b1; end
      OP_XOR: begin
        res        = s_m ^ d_m;
        wb_o       = 1'b1;
        flag_touch = 1'b1;
        v_nxt      = s_m[msb] & d_m[msb];
        c_nxt      = ~res_zero;
      end
      default: ;
    endcase
  end

  assign flags_nxt = '{v: v_nxt, n: res[msb], z: res_zero, c: c_nxt};

  alu2_flagreg u_flags (
    .clk(clk), .rst_n(rst_n), .load_i(flag_en_i & flag_touch),
    .nxt_i(flags_nxt), .q_o(flags_q)
  );

  assign res_o = res;
  assign v_o   = flags_q.v;
  assign n_o   = flags_q.n;
  assign z_o   = flags_q.z;
  assign c_o   = flags_q.c;
endmodule

// File: rtl/alu2_checker.sv
module alu2_checker
  import alu2_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    op_i,
  input logic [1:0]    wsel_i,
  input logic          flag_en_i,
  input logic [AW-1:0] res_o,
  input logic          wb_o,
  input logic          v_o,
  input logic          n_o,
  input logic          z_o,
  input logic          c_o,
  input logic          flag_touch
);
  logic res_top;
  logic upd;
  assign res_top = (wsel_i == 2'd0) ? res_o[BW-1] :
                   (wsel_i == 2'd1) ? res_o[WW-1] : res_o[AW-1];
  assign upd = flag_en_i && flag_touch;

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable({v_o, n_o, z_o, c_o})); // R9
  AST_NO_WB_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP || op_i == OP_BIT) |-> !wb_o); // R7
  AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel_i == 2'd0) |-> (res_o[AW-1:BW] == '0)); // R5
  AST_N_TRACKS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (n_o == $past(res_top))); // R5
  AST_Z_TRACKS_RES: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (z_o == ($past(res_o) == '0))); // R5
  AST_LOGIC_C_NOT_Z: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en_i && (op_i == OP_BIT || op_i == OP_AND || op_i == OP_XOR)) |=> (c_o == !z_o)); // R8
  AST_TEST_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en_i && (op_i == OP_BIT || op_i == OP_AND)) |=> !v_o); // R7
  AST_MOVE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_MOV || op_i == OP_BIC || op_i == OP_BIS) |=> $stable({v_o, n_o, z_o, c_o})); // R6
  AST_UNDEF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= 4'd12) |-> (!wb_o && res_o == '0)); // R11
endmodule

bind dual_op_alu alu2_checker u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .wsel_i(wsel_i), .flag_en_i(flag_en_i),
  .res_o(res_o), .wb_o(wb_o), .v_o(v_o), .n_o(n_o), .z_o(z_o), .c_o(c_o),
  .flag_touch(flag_touch)
);

// File: tb/tb_dual_op_alu.sv
module tb_dual_op_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  wsel_i = '0;
  logic [19:0] src_i = '0;
  logic [19:0] dst_i = '0;
  logic        cin_i = 1'b0;
  logic        flag_en_i = 1'b0;
  logic [19:0] res_o;
  logic        wb_o, v_o, n_o, z_o, c_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] model_fl = '0;

  always #5 clk = ~clk;

  dual_op_alu dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .wsel_i(wsel_i), .src_i(src_i),
    .dst_i(dst_i), .cin_i(cin_i), .flag_en_i(flag_en_i), .res_o(res_o),
    .wb_o(wb_o), .v_o(v_o), .n_o(n_o), .z_o(z_o), .c_o(c_o)
  );

  // src, dst, cin; every operand is valid packed BCD
  localparam logic [40:0] PAIRS [8] = '{
    {20'h00001, 20'h99999, 1'b0},
    {20'h12345, 20'h54321, 1'b1},
    {20'h00000, 20'h00000, 1'b0},
    {20'h80808, 20'h80808, 1'b0},
    {20'h45678, 20'h98765, 1'b1},
    {20'h55555, 20'h44445, 1'b0},
    {20'h99999, 20'h00000, 1'b1},
    {20'h09090, 20'h90909, 1'b1}
  };

  typedef struct packed {
    logic [19:0] r;
    logic wb, t, v, n, z, c;
  } exp_t;

  function automatic exp_t model(int op, int w, longint s0, longint d0, int ci);
    longint W, m, half, s, d, b, cc, tot, sb, sd, st, vs, vd, p, r;
    exp_t e;
    W = (w == 0) ? 8 : (w == 1) ? 16 : 20;
    m = (longint'(1) << W) - 1;
    half = longint'(1) << (W - 1);
    s = s0 & m; d = d0 & m; r = 0;
    e = '0;
    case (op)
      0: begin r = s; e.wb = 1; end
      1, 2, 3, 4, 5: begin
        b  = (op >= 3) ? (~s) & m : s;
        cc = (op == 1) ? 0 : (op == 3 || op == 5) ? 1 : ci;
        tot = d + b + cc;
        r = tot & m;
        e.c = ((tot >> W) & 1) != 0;
        sb = (b >= half) ? b - (m + 1) : b;
        sd = (d >= half) ? d - (m + 1) : d;
        st = sd + sb + cc;
        e.v = (st >= half) || (st < -half);
        e.wb = (op != 5); e.t = 1;
      end
      6: begin
        vs = 0; vd = 0; p = 1;
        for (int k = 0; k < W / 4; k++) begin
          vs += ((s >> (4 * k)) & 15) * p;
          vd += ((d >> (4 * k)) & 15) * p;
          p *= 10;
        end
        tot = vs + vd + ci;
        e.c = tot >= p;
        tot = tot % p;
        for (int k = 0; k < W / 4; k++) begin
          r |= (tot % 10) << (4 * k);
          tot /= 10;
        end
        e.wb = 1; e.t = 1;
      end
      7, 11: begin r = s & d; e.wb = (op == 11); e.t = 1; e.c = (r != 0); end
      8: begin r = (~s) & d & m; e.wb = 1; end
      9: begin r = s | d; e.wb = 1; end
      10: begin
        r = s ^ d; e.wb = 1; e.t = 1;
        e.v = (s >= half) && (d >= half); e.c = (r != 0);
      end
      default: ;
    endcase
    e.r = r[19:0];
    e.n = (r >= half);
    e.z = (r == 0);
    return e;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive at negedge; result checked 1 ns later, flags after the next rising edge
  task automatic step(string req, int op, int w, logic [19:0] s, logic [19:0] d, logic ci,
                      logic en, logic [19:0] xr, logic xwb, logic [3:0] xfl);
    op_i = 4'(op); wsel_i = 2'(w); src_i = s; dst_i = d; cin_i = ci; flag_en_i = en;
    #1;
    check(req, "result", 32'(res_o), 32'(xr));
    check(req, "wb", 32'(wb_o), 32'(xwb));
    @(posedge clk); @(negedge clk);
    check(req, "flags", 32'({v_o, n_o, z_o, c_o}), 32'(xfl));
    model_fl = xfl;
  endtask

  task automatic run_model(string req, int op, int w, logic [19:0] s, logic [19:0] d,
                           logic ci, logic en);
    exp_t e;
    e = model(op, w, longint'(s), longint'(d), int'(ci));
    step(req, op, w, s, d, ci, en, e.r, e.wb, (en && e.t) ? {e.v, e.n, e.z, e.c} : model_fl);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "flags in reset", 32'({v_o, n_o, z_o, c_o}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "flags after reset", 32'({v_o, n_o, z_o, c_o}), 32'h0);

    // table walk: every opcode (R1 R2 R3 R4 R6 R7 R8 R11) at every width (R5)
    for (int op = 0; op < 16; op++)
      for (int w = 0; w < 4; w++)
        for (int p = 0; p < 8; p++)
          run_model("R1-table", op, w, PAIRS[p][40:21], PAIRS[p][20:1], PAIRS[p][0], 1'b1);

    // directed corner cases, flags as {V,N,Z,C}
    step("R2", 1, 0, 20'h00001, 20'h0007F, 1'b0, 1'b1, 20'h00080, 1'b1, 4'b1100);
    step("R2", 3, 1, 20'h00001, 20'h00000, 1'b0, 1'b1, 20'h0FFFF, 1'b1, 4'b0100);
    step("R5", 1, 2, 20'h00001, 20'hFFFFF, 1'b0, 1'b1, 20'h00000, 1'b1, 4'b0011);
    step("R5", 1, 0, 20'h000FF, 20'hAB001, 1'b0, 1'b1, 20'h00000, 1'b1, 4'b0011);
    step("R4", 6, 0, 20'h00001, 20'h00099, 1'b0, 1'b1, 20'h00000, 1'b1, 4'b0011);
    step("R4", 6, 1, 20'h00001, 20'h00999, 1'b1, 1'b1, 20'h01001, 1'b1, 4'b0000);
    step("R4", 6, 2, 20'h00000, 20'h99999, 1'b1, 1'b1, 20'h00000, 1'b1, 4'b0011);
    step("R3", 5, 1, 20'h01234, 20'h01234, 1'b0, 1'b1, 20'h00000, 1'b0, 4'b0011);
    step("R6", 0, 1, 20'h00000, 20'h05555, 1'b0, 1'b1, 20'h00000, 1'b1, 4'b0011);
    step("R6", 9, 1, 20'h08000, 20'h00001, 1'b0, 1'b1, 20'h08001, 1'b1, 4'b0011);
    step("R8", 10, 1, 20'h08000, 20'h08000, 1'b0, 1'b1, 20'h00000, 1'b1, 4'b1010);
    step("R9", 1, 0, 20'h000FF, 20'h00001, 1'b0, 1'b0, 20'h00000, 1'b1, 4'b1010);
    step("R7", 7, 0, 20'h00080, 20'h000C0, 1'b0, 1'b1, 20'h00080, 1'b0, 4'b0101);
    step("R7", 11, 1, 20'h0F0F0, 20'h00F0F, 1'b0, 1'b1, 20'h00000, 1'b1, 4'b0010);
    step("R11", 13, 1, 20'h01111, 20'h02222, 1'b1, 1'b1, 20'h00000, 1'b0, 4'b0010);
    step("R8", 10, 0, 20'h00080, 20'h00001, 1'b0, 1'b1, 20'h00081, 1'b1, 4'b0101);

    // asynchronous reset mid-run clears nonzero flags
    rst_n = 1'b0;
    #1;
    check("R10", "async clear", 32'({v_o, n_o, z_o, c_o}), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    model_fl = '0;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule